// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Front End

This block is the digital side of a two-channel 10-bit DAC. It is a serial slave. An external host drives a chip-select line (active low), a serial clock and a data line. The block samples that serial stream in the system clock domain. It assembles each frame and acts on the frame only when chip-select returns high. Each channel has two storage stages. The input stage holds a code that is staged but not yet visible. The DAC stage holds the code that is presented on the outputs. A sleep state places the outputs in high impedance, which this block reports through an enable flag.

A frame is 16 bits, sent most significant bit first. Bits 15..12 hold the command. Bits 11..2 hold the 10-bit code. Bits 1..0 are ignored. Data is taken on each rising serial clock edge while chip-select is low, which is mode 0. A command decides three things separately: which input stage is loaded, whether the DAC stages are refreshed from the input stages, and whether the part wakes or sleeps. The serial pins are passed through two-flop synchronisers, so the serial clock must be several times slower than the system clock.

Top module: `dual_dac_front`

## Requirements
- R1: After synchronous reset, both DAC outputs and both input stages are 0 and `out_en` is 1 (awake).
- R2: Frames are taken MSB first on rising `sck` while `cs_n` is low. The outputs change only once chip-select has risen, and they settle within 6 `clk` cycles of that rise.
- R3: A frame whose bit count is not exactly 16 (for example 15 or 17 bits) is discarded and changes no state.
- R4: Command 4'b0000 changes nothing.
- R5: Command 4'b0001 loads input stage A with the code, and 4'b0010 loads input stage B. Neither command changes the outputs or `out_en`.
- R6: Command 4'b1000 copies both input stages into the DAC stages and sets `out_en` to 1.
- R7: Command 4'b1001 loads input stage A and then refreshes both DAC stages, so A takes the new code and B takes input stage B. Command 4'b1010 does the same for channel B. Both commands set `out_en` to 1.
- R8: Command 4'b1101 sets `out_en` to 1 and leaves all stages unchanged. Command 4'b1110 clears `out_en` to 0 and leaves all stages unchanged.
- R9: Command 4'b1111 loads the code into both input stages and both DAC stages, and sets `out_en` to 1.
- R10: Codes 4'b0011 through 4'b0111, 4'b1011 and 4'b1100 change no state, including the input stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from host (asynchronous) |
| cs_n | input | 1 | Frame select, active low (asynchronous) |
| mosi | input | 1 | Serial data from host (asynchronous) |
| dac_a | output | 10 | Channel A DAC stage |
| dac_b | output | 10 | Channel B DAC stage |
| out_en | output | 1 | 1 = outputs driven, 0 = high impedance (sleep) |

## Verification
Some faults are hidden by the double buffer. A wrong input stage does not appear at the ports when it is written. It appears only at the next refresh command, which may be several frames later. The bench therefore follows every load-only, reserved and rejected frame with a refresh that exposes both input stages. A wrong bit counter or wrong frame alignment appears within about four clock cycles of chip-select rising: a frame that should have been dropped is applied, or the code lands on the wrong bits. A wrong power state appears at once on `out_en`.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [CMD_W-1:0] {
    OP_NOP      = 4'b0000,
    OP_LOAD_A   = 4'b0001,
    OP_LOAD_B   = 4'b0010,
    OP_XFER     = 4'b1000,
    OP_LDUPD_A  = 4'b1001,
    OP_LDUPD_B  = 4'b1010,
    OP_WAKE     = 4'b1101,
    OP_SLEEP    = 4'b1110,
    OP_LDUPD_AB = 4'b1111
  } op_e;

  typedef struct packed {
    logic stage_a;   // write code into input stage A
    logic stage_b;   // write code into input stage B
    logic refresh;   // copy input stages to DAC stages
    logic wake;
    logic sleep;
  } act_t;

  function automatic act_t decode_op(input logic [CMD_W-1:0] code);
    act_t a;
    a = '0;
    case (code)
      OP_LOAD_A:   a.stage_a = 1'b1;
      OP_LOAD_B:   a.stage_b = 1'b1;
      OP_XFER:     begin a.refresh = 1'b1; a.wake = 1'b1; end
      OP_LDUPD_A:  begin a.stage_a = 1'b1; a.refresh = 1'b1; a.wake = 1'b1; end
      OP_LDUPD_B:  begin a.stage_b = 1'b1; a.refresh = 1'b1; a.wake = 1'b1; end
      OP_WAKE:     a.wake = 1'b1;
      OP_SLEEP:    a.sleep = 1'b1;
      OP_LDUPD_AB: begin
        a.stage_a = 1'b1; a.stage_b = 1'b1; a.refresh = 1'b1; a.wake = 1'b1;
      end
      default:     a = '0;  // no-op and reserved codes
    endcase
    return a;
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= din;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/dacfe_rx.sv
module dacfe_rx #(
  parameter int CMD_W  = 4,
  parameter int DATA_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  output logic              frame_ok,
  output logic [CMD_W-1:0]  frame_cmd,
  output logic [DATA_W-1:0] frame_data
);

  localparam int FRAME_BITS = CMD_W + DATA_W + PAD_W;
  localparam int CNT_MAX    = FRAME_BITS + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int DATA_LSB   = PAD_W;
  localparam int CMD_LSB    = PAD_W + DATA_W;

  logic                  sck_q, cs_q;
  logic                  sck_rise, cs_fall, cs_rise;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_n_s;
    end
  end

  assign sck_rise = sck_s & ~sck_q;
  assign cs_fall  = ~cs_n_s & cs_q;
  assign cs_rise  = cs_n_s & ~cs_q;

  // shift register and saturating bit counter
  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
      bits  <= '0;
    end else if (cs_fall) begin
      shreg <= '0;
      bits  <= '0;
    end else if (!cs_n_s && sck_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
      if (bits != CNT_W'(CNT_MAX)) bits <= bits + 1'b1;
    end
  end

  // frame commit on chip-select release
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_ok   <= 1'b0;
      frame_cmd  <= '0;
      frame_data <= '0;
    end else begin
      frame_ok <= cs_rise && (bits == CNT_W'(FRAME_BITS));
      if (cs_rise) begin
        frame_cmd  <= shreg[CMD_LSB +: CMD_W];
        frame_data <= shreg[DATA_LSB +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/dacfe_decode.sv
module dacfe_decode
  import dacfe_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_ok,
  input  logic [CMD_W-1:0]  frame_cmd,
  input  logic [DATA_W-1:0] frame_data,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              out_en
);

  act_t              act;
  logic [DATA_W-1:0] in_a, in_b;
  logic [DATA_W-1:0] in_a_nx, in_b_nx;

  always_comb begin
    act     = frame_ok ? decode_op(frame_cmd) : '0;
    in_a_nx = act.stage_a ? frame_data : in_a;
    in_b_nx = act.stage_b ? frame_data : in_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      in_a   <= '0;
      in_b   <= '0;
      dac_a  <= '0;
      dac_b  <= '0;
      out_en <= 1'b1;
    end else begin
      in_a <= in_a_nx;
      in_b <= in_b_nx;
      if (act.refresh) begin
        dac_a <= in_a_nx;
        dac_b <= in_b_nx;
      end
      if (act.wake)       out_en <= 1'b1;
      else if (act.sleep) out_en <= 1'b0;
    end
  end

endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
  import dacfe_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int PAD_W     = 2,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              out_en
);

  logic [2:0]        pins_s;
  logic              frame_ok;
  logic [CMD_W-1:0]  frame_cmd;
  logic [DATA_W-1:0] frame_data;

  // bit 2: cs_n (idles high), bit 1: sck, bit 0: mosi
  dacfe_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STGS),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({cs_n, sck, mosi}),
    .dout(pins_s)
  );

  dacfe_rx #(
    .CMD_W (CMD_W),
    .DATA_W(DATA_W),
    .PAD_W (PAD_W)
  ) u_rx (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (pins_s[1]),
    .cs_n_s    (pins_s[2]),
    .mosi_s    (pins_s[0]),
    .frame_ok  (frame_ok),
    .frame_cmd (frame_cmd),
    .frame_data(frame_data)
  );

  dacfe_decode #(
    .DATA_W(DATA_W)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .frame_ok  (frame_ok),
    .frame_cmd (frame_cmd),
    .frame_data(frame_data),
    .dac_a     (dac_a),
    .dac_b     (dac_b),
    .out_en    (out_en)
  );

endmodule

// File: rtl/dual_dac_front_chk.sv
module dual_dac_front_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_ok,
  input logic [3:0]        frame_cmd,
  input logic [DATA_W-1:0] frame_data,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              out_en
);

  logic reserved;
  assign reserved = (frame_cmd inside {4'b0011, 4'b0100, 4'b0101, 4'b0110,
                                       4'b0111, 4'b1011, 4'b1100});

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dac_a == '0 && dac_b == '0 && out_en));

  p_quiet_between_frames_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_ok |=> ($stable(dac_a) && $stable(dac_b) && $stable(out_en)));

  p_nop_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && frame_cmd == 4'b0000) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(out_en)));

  p_load_only_r5: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && (frame_cmd == 4'b0001 || frame_cmd == 4'b0010)) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(out_en)));

  p_xfer_wakes_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && frame_cmd == 4'b1000) |=> out_en);

  p_update_a_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && frame_cmd == 4'b1001) |=> (dac_a == $past(frame_data) && out_en));

  p_update_b_r7: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && frame_cmd == 4'b1010) |=> (dac_b == $past(frame_data) && out_en));

  p_wake_only_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && frame_cmd == 4'b1101) |=> (out_en && $stable(dac_a) && $stable(dac_b)));

  p_sleep_only_r8: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && frame_cmd == 4'b1110) |=> (!out_en && $stable(dac_a) && $stable(dac_b)));

  p_broadcast_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && frame_cmd == 4'b1111) |=>
      (dac_a == $past(frame_data) && dac_b == $past(frame_data) && out_en));

  p_reserved_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && reserved) |=>
      ($stable(dac_a) && $stable(dac_b) && $stable(out_en)));

endmodule

bind dual_dac_front dual_dac_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_ok  (frame_ok),
  .frame_cmd (frame_cmd),
  .frame_data(frame_data),
  .dac_a     (dac_a),
  .dac_b     (dac_b),
  .out_en    (out_en)
);

// File: tb/test_dual_dac_front.sv
module test_dual_dac_front;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       mosi = 1'b0;
  logic [9:0] dac_a, dac_b;
  logic       out_en;

  always #2 clk = ~clk;  // 250 MHz

  dual_dac_front i_dual_dac_front (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .dac_a(dac_a), .dac_b(dac_b), .out_en(out_en)
  );

  typedef struct {
    logic [9:0] a;
    logic [9:0] b;
    logic       en;
    string      tag;
  } exp_t;

  exp_t q[$];
  event frame_done;
  int   checks = 0;
  int   fails  = 0;
  bit   finished = 0;

  // reference model
  logic [9:0] m_ia = '0, m_ib = '0, m_da = '0, m_db = '0;
  logic       m_en = 1'b1;

  task automatic check(input string tag, input logic [9:0] a, input logic [9:0] b,
                       input logic en);
    checks++;
    if (dac_a !== a || dac_b !== b || out_en !== en) begin
      fails++;
      $display("FAIL %s: got a=%h b=%h en=%b expected a=%h b=%h en=%b",
               tag, dac_a, dac_b, out_en, a, b, en);
    end
  endtask

  task automatic model(input logic [3:0] c, input logic [9:0] d);
    case (c)
      4'b0001: m_ia = d;
      4'b0010: m_ib = d;
      4'b1000: begin m_da = m_ia; m_db = m_ib; m_en = 1; end
      4'b1001: begin m_ia = d; m_da = m_ia; m_db = m_ib; m_en = 1; end
      4'b1010: begin m_ib = d; m_da = m_ia; m_db = m_ib; m_en = 1; end
      4'b1101: m_en = 1;
      4'b1110: m_en = 0;
      4'b1111: begin m_ia = d; m_ib = d; m_da = d; m_db = d; m_en = 1; end
      default: ;
    endcase
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: sends nbits of {cmd,data,2'b00} MSB first, extra bits are 0
  task automatic send(input string tag, input logic [3:0] c, input logic [9:0] d,
                      input int nbits);
    logic [15:0] w;
    exp_t e;
    w = {c, d, 2'b00};
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b0;
      sck = 1'b0; wait_clk(4);
      sck = 1'b1; wait_clk(4);
    end
    sck = 1'b0;
    wait_clk(4);
    // R2: nothing changes before chip-select releases
    check({tag, " R2 hold before cs release"}, m_da, m_db, m_en);
    if (nbits == 16) model(c, d);
    e.a = m_da; e.b = m_db; e.en = m_en; e.tag = tag;
    q.push_back(e);
    cs_n = 1'b1;
    -> frame_done;
    wait_clk(16);
  endtask

  // monitor: R2 latency bound of 6 cycles after cs release
  initial begin
    forever begin
      exp_t e;
      @(frame_done);
      wait_clk(6);
      e = q.pop_front();
      check(e.tag, e.a, e.b, e.en);
    end
  end

  initial begin
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    check("R1 reset state", 10'h000, 10'h000, 1'b1);

    send("R9 broadcast",             4'b1111, 10'h2AA, 16);
    send("R5 load A only",           4'b0001, 10'h155, 16);
    send("R5 load B only",           4'b0010, 10'h0F0, 16);
    send("R6 transfer both",         4'b1000, 10'h000, 16);
    send("R8 sleep",                 4'b1110, 10'h3FF, 16);
    send("R4 no-op",                 4'b0000, 10'h3FF, 16);
    send("R8 wake",                  4'b1101, 10'h000, 16);
    send("R7 load+update A",         4'b1001, 10'h3FF, 16);
    send("R7 load+update B",         4'b1010, 10'h001, 16);
    send("R10 reserved 0011",        4'b0011, 10'h200, 16);
    send("R10 reserved 0111",        4'b0111, 10'h111, 16);
    send("R10 reserved 1011",        4'b1011, 10'h222, 16);
    send("R10 reserved 1100",        4'b1100, 10'h333, 16);
    send("R8 sleep again",           4'b1110, 10'h000, 16);
    send("R10 reserved 0100 asleep", 4'b0100, 10'h044, 16);
    send("R10 input stages intact",  4'b1000, 10'h000, 16);
    send("R3 short 15-bit frame",    4'b1111, 10'h0AB, 15);
    send("R3 long 17-bit frame",     4'b1111, 10'h0CD, 17);
    send("R3 stages after bad len",  4'b1000, 10'h000, 16);
    send("R2 msb-first code",        4'b1111, 10'h123, 16);
    send("R7 B keeps staged value",  4'b1001, 10'h080, 16);

    wait_clk(4);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule